// File: doc/BRIEF.md
# Slot Hotplug Event Controller

This block records insertion and removal events for a bank of expansion slots and shows them to software through four word registers. Each slot drives an insert pulse and a remove pulse. An accepted event overwrites the previous record. The `up` word then holds the inserted slot, or the `down` word holds the removed slot. In the same cycle a one-cycle `gpe_set` pulse requests that status bit 1 of the general-purpose event block be set. The interrupt logic that consumes this pulse lies outside the block.

While `cold_boot` is high, insertions are treated as devices that were present at power-up and raise nothing. Removals are reported in every case. Software ejects a slot by writing a bit pattern to the eject register. The lowest set bit of that pattern names the slot, and `eject_pulse` then carries a one-cycle one-hot pulse toward it. Slots that the `fixed_mask` input marks as not hot-removable are cleared from the removable report and are never ejected. That mask is sampled on every reset.

All ports are plain level or pulse signals and carry no handshake. A register write completes in the cycle it is presented. Read data is a combinational function of `rd_addr`.

Top module: `slot_hp_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `up` and `down` read 0, and `gpe_set` and `eject_pulse` are 0.
- R2: An insert pulse with `cold_boot` low causes the following changes one clock later: `up` reads only that slot's bit, `down` reads 0, and `gpe_set` is high for exactly one cycle.
- R3: A remove pulse causes the following changes one clock later: `down` reads only that slot's bit, `up` reads 0, and `gpe_set` pulses once. This holds whatever the level of `cold_boot`.
- R4: An insert pulse while `cold_boot` is high changes neither `up` nor `down` and produces no `gpe_set`.
- R5: If insert and remove pulses arrive in the same cycle, the insertion is handled first and the removal second. The result is `up` = 0, `down` = the removed slot's bit, and a single `gpe_set` pulse.
- R6: If one event vector has several bits set in the same cycle, only the lowest-numbered slot is recorded.
- R7: A write to the eject register (byte offset 0x8) causes a pulse one clock later. `eject_pulse` is high for one cycle and is one-hot on the lowest set bit of the written data.
- R8: No eject pulse is produced in two cases: the selected slot is marked fixed, or the written data is zero.
- R9: The eject register reads 0.
- R10: The removable register (offset 0xC) reads the inverse of `fixed_mask` as sampled during the last reset. Later changes of `fixed_mask` and writes to the register have no effect on it.
- R11: The register map is up = 0x0, down = 0x4, eject = 0x8, removable = 0xC, decoded from `rd_addr[3:2]` / `wr_addr[3:2]`. Writes to up and down are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; samples `fixed_mask` |
| cold_boot | input | 1 | High while the system is still being assembled |
| ins_evt | input | NSLOT | Per-slot insertion pulses |
| rem_evt | input | NSLOT | Per-slot removal pulses |
| fixed_mask | input | NSLOT | 1 = slot not hot-removable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write byte address |
| wr_data | input | NSLOT | Register write data |
| rd_addr | input | AW | Register read byte address |
| rd_data | output | NSLOT | Register read data (combinational) |
| gpe_set | output | 1 | One-cycle request to set event status bit 1 |
| eject_pulse | output | NSLOT | One-cycle one-hot eject command |

## Verification
Two pairs of functions can meet in the same cycle. The first pair is an insertion and a removal in the event path. The second pair is a hotplug event together with an eject write. The bench raises both event vectors on one clock and expects the combined record that R5 defines. Separately, it issues an eject write on the same clock as a removal pulse and checks that each side produces its own result with no interference: the `down` record with its `gpe_set`, and the `eject_pulse`.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  typedef enum logic [1:0] {
    SEL_UP    = 2'd0,
    SEL_DOWN  = 2'd1,
    SEL_EJECT = 2'd2,
    SEL_RMV   = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_LSB = 2;
endpackage

// File: rtl/slot_hp_event.sv
module slot_hp_event #(
  parameter int unsigned NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cold_boot,
  input  logic [NSLOT-1:0] ins_evt,
  input  logic [NSLOT-1:0] rem_evt,
  output logic [NSLOT-1:0] up_q,
  output logic [NSLOT-1:0] down_q,
  output logic             gpe_set
);
  logic [NSLOT-1:0] ins_live;
  logic [NSLOT-1:0] ins_one;
  logic [NSLOT-1:0] rem_one;

  // Insertions during system assembly are suppressed entirely.
  assign ins_live = cold_boot ? '0 : ins_evt;
  assign ins_one  = ins_live & (~ins_live + 1'b1);
  assign rem_one  = rem_evt & (~rem_evt + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= '0;
      down_q  <= '0;
      gpe_set <= 1'b0;
    end else begin
      gpe_set <= (|ins_one) | (|rem_one);
      // Removal is processed after insertion, so it owns the final record.
      if (|rem_one) begin
        up_q   <= '0;
        down_q <= rem_one;
      end else if (|ins_one) begin
        up_q   <= ins_one;
        down_q <= '0;
      end
    end
  end
endmodule

// File: rtl/slot_hp_eject.sv
module slot_hp_eject #(
  parameter int unsigned NSLOT = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] fixed_mask,
  input  logic             ej_wr,
  input  logic [NSLOT-1:0] ej_data,
  output logic [NSLOT-1:0] rmv_q,
  output logic [NSLOT-1:0] eject_pulse
);
  logic [NSLOT-1:0] pick;

  assign pick = ej_data & (~ej_data + 1'b1);

  // Removable mask: one flop per slot, reloaded only while reset is held.
  for (genvar s = 0; s < NSLOT; s++) begin : g_rmv
    always_ff @(posedge clk) begin
      if (rst) rmv_q[s] <= ~fixed_mask[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        eject_pulse <= '0;
    else if (ej_wr) eject_pulse <= pick & rmv_q;
    else            eject_pulse <= '0;
  end
endmodule

// File: rtl/slot_hp_regs.sv
module slot_hp_regs
  import slot_hp_pkg::*;
#(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned AW    = 4
) (
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_en,
  input  logic [AW-1:0]    rd_addr,
  input  logic [NSLOT-1:0] up_q,
  input  logic [NSLOT-1:0] down_q,
  input  logic [NSLOT-1:0] rmv_q,
  output logic             ej_wr,
  output logic [NSLOT-1:0] rd_data
);
  reg_sel_e rsel;
  reg_sel_e wsel;

  assign rsel  = reg_sel_e'(rd_addr[SEL_LSB +: 2]);
  assign wsel  = reg_sel_e'(wr_addr[SEL_LSB +: 2]);
  assign ej_wr = wr_en && (wsel == SEL_EJECT);

  always_comb begin
    unique case (rsel)
      SEL_UP:   rd_data = up_q;
      SEL_DOWN: rd_data = down_q;
      SEL_RMV:  rd_data = rmv_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl #(
  parameter int unsigned NSLOT = 32,
  parameter int unsigned AW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cold_boot,
  input  logic [NSLOT-1:0] ins_evt,
  input  logic [NSLOT-1:0] rem_evt,
  input  logic [NSLOT-1:0] fixed_mask,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [NSLOT-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [NSLOT-1:0] rd_data,
  output logic             gpe_set,
  output logic [NSLOT-1:0] eject_pulse
);
  logic [NSLOT-1:0] up_q;
  logic [NSLOT-1:0] down_q;
  logic [NSLOT-1:0] rmv_q;
  logic             ej_wr;

  slot_hp_event #(.NSLOT(NSLOT)) u_event (
    .clk(clk), .rst(rst), .cold_boot(cold_boot),
    .ins_evt(ins_evt), .rem_evt(rem_evt),
    .up_q(up_q), .down_q(down_q), .gpe_set(gpe_set)
  );

  slot_hp_eject #(.NSLOT(NSLOT)) u_eject (
    .clk(clk), .rst(rst), .fixed_mask(fixed_mask),
    .ej_wr(ej_wr), .ej_data(wr_data),
    .rmv_q(rmv_q), .eject_pulse(eject_pulse)
  );

  slot_hp_regs #(.NSLOT(NSLOT), .AW(AW)) u_regs (
    .wr_addr(wr_addr), .wr_en(wr_en), .rd_addr(rd_addr),
    .up_q(up_q), .down_q(down_q), .rmv_q(rmv_q),
    .ej_wr(ej_wr), .rd_data(rd_data)
  );
endmodule

// File: rtl/slot_hp_ctrl_chk.sv
module slot_hp_ctrl_chk #(
  parameter int unsigned NSLOT = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cold_boot,
  input logic [NSLOT-1:0] ins_evt,
  input logic [NSLOT-1:0] rem_evt,
  input logic [NSLOT-1:0] up_q,
  input logic [NSLOT-1:0] down_q,
  input logic [NSLOT-1:0] rmv_q,
  input logic             gpe_set,
  input logic [NSLOT-1:0] eject_pulse
);
  AST_EVENT_RAISES_GPE: assert property (@(posedge clk) disable iff (rst)
    ((|rem_evt) || ((|ins_evt) && !cold_boot)) |=> gpe_set); // R2
  AST_QUIET_NO_GPE: assert property (@(posedge clk) disable iff (rst)
    (!(|rem_evt) && !((|ins_evt) && !cold_boot)) |=> !gpe_set); // R4
  AST_REMOVE_CLEARS_UP: assert property (@(posedge clk) disable iff (rst)
    (|rem_evt) |=> (up_q == '0) && $onehot(down_q)); // R3
  AST_RECORD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    gpe_set |-> $onehot(up_q | down_q)); // R6
  AST_EJECT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eject_pulse)); // R7
  AST_EJECT_NOT_FIXED: assert property (@(posedge clk) disable iff (rst)
    (eject_pulse & ~rmv_q) == '0); // R8
  AST_RMV_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(rmv_q)); // R10
endmodule

bind slot_hp_ctrl slot_hp_ctrl_chk #(.NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .cold_boot(cold_boot),
  .ins_evt(ins_evt), .rem_evt(rem_evt),
  .up_q(up_q), .down_q(down_q), .rmv_q(rmv_q),
  .gpe_set(gpe_set), .eject_pulse(eject_pulse)
);

// File: tb/test_slot_hp_ctrl.sv
`timescale 1ns/1ps
module test_slot_hp_ctrl;
  localparam int N = 32;
  localparam logic [3:0] A_UP = 4'h0, A_DN = 4'h4, A_EJ = 4'h8, A_RM = 4'hC;
  localparam logic [N-1:0] FIX0 = 32'h0000_0015;

  logic clk = 0, rst = 1, cold_boot = 0, wr_en = 0;
  logic [N-1:0] ins_evt = '0, rem_evt = '0, fixed_mask = FIX0, wr_data = '0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [N-1:0] rd_data, eject_pulse;
  logic gpe_set;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slot_hp_ctrl i_slot_hp_ctrl (
    .clk(clk), .rst(rst), .cold_boot(cold_boot), .ins_evt(ins_evt),
    .rem_evt(rem_evt), .fixed_mask(fixed_mask), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .gpe_set(gpe_set), .eject_pulse(eject_pulse)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  // Apply stimulus for one clock; outputs are checked at the next negedge.
  task automatic step(input logic [N-1:0] ins, input logic [N-1:0] rem,
                      input logic we, input logic [3:0] wa, input logic [N-1:0] wd);
    @(negedge clk);
    ins_evt = ins; rem_evt = rem; wr_en = we; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    ins_evt = '0; rem_evt = '0; wr_en = 0;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    rst = 1; fixed_mask = FIX0;
    repeat (3) @(negedge clk);
    rd(A_UP, v); check("R1 up in reset", v, '0);
    rd(A_DN, v); check("R1 down in reset", v, '0);
    check("R1 gpe in reset", {31'b0, gpe_set}, '0);
    rst = 0;
    @(negedge clk);
    check("R1 eject after reset", eject_pulse, '0);
    check("R1 gpe after reset", {31'b0, gpe_set}, '0);
  endtask

  task automatic t_hot_insert;
    logic [N-1:0] v;
    step(32'h0000_0100, '0, 0, A_UP, '0);
    check("R2 gpe pulse", {31'b0, gpe_set}, 1);
    rd(A_UP, v); check("R2 up", v, 32'h0000_0100);
    rd(A_DN, v); check("R2 down", v, '0);
    @(negedge clk);
    check("R2 gpe single cycle", {31'b0, gpe_set}, 0);
  endtask

  task automatic t_cold;
    logic [N-1:0] v;
    cold_boot = 1;
    step(32'h0000_0008, '0, 0, A_UP, '0);
    check("R4 no gpe on cold insert", {31'b0, gpe_set}, 0);
    rd(A_UP, v); check("R4 up unchanged", v, 32'h0000_0100);
    step('0, 32'h8000_0000, 0, A_UP, '0);
    check("R3 gpe on cold removal", {31'b0, gpe_set}, 1);
    rd(A_DN, v); check("R3 down", v, 32'h8000_0000);
    rd(A_UP, v); check("R3 up cleared", v, '0);
    cold_boot = 0;
  endtask

  task automatic t_same_cycle;
    logic [N-1:0] v;
    step(32'h0000_0040, 32'h0000_0200, 0, A_UP, '0);
    check("R5 gpe", {31'b0, gpe_set}, 1);
    rd(A_UP, v); check("R5 up", v, '0);
    rd(A_DN, v); check("R5 down", v, 32'h0000_0200);
    @(negedge clk);
    check("R5 single gpe", {31'b0, gpe_set}, 0);
  endtask

  task automatic t_multi;
    logic [N-1:0] v;
    step(32'h0101_1000, '0, 0, A_UP, '0);
    rd(A_UP, v); check("R6 lowest insert", v, 32'h0000_1000);
    rd(A_DN, v); check("R6 down cleared", v, '0);
  endtask

  task automatic t_eject;
    logic [N-1:0] v;
    step('0, '0, 1, A_EJ, 32'h00F0_0A00);
    check("R7 eject lowest", eject_pulse, 32'h0000_0200);
    @(negedge clk);
    check("R7 eject one cycle", eject_pulse, '0);
    rd(A_EJ, v); check("R9 eject reads zero", v, '0);
  endtask

  task automatic t_eject_blocked;
    step('0, '0, 1, A_EJ, 32'h0000_0014);
    check("R8 fixed slot not ejected", eject_pulse, '0);
    step('0, '0, 1, A_EJ, '0);
    check("R8 zero write no eject", eject_pulse, '0);
  endtask

  task automatic t_regs;
    logic [N-1:0] v;
    rd(A_RM, v); check("R10 removable", v, ~FIX0);
    step('0, '0, 1, A_RM, 32'h0);
    rd(A_RM, v); check("R10 write ignored", v, ~FIX0);
    fixed_mask = 32'hFFFF_0000;
    @(negedge clk);
    rd(A_RM, v); check("R10 live mask ignored", v, ~FIX0);
    step('0, '0, 1, A_UP, 32'hDEAD_BEEF);
    step('0, '0, 1, A_DN, 32'hDEAD_BEEF);
    rd(A_UP, v); check("R11 up write ignored", v, 32'h0000_1000);
    rd(A_DN, v); check("R11 down write ignored", v, '0);
  endtask

  task automatic t_concurrent;
    logic [N-1:0] v;
    step('0, 32'h0000_0002, 1, A_EJ, 32'h0000_0002);
    check("R3 gpe with eject", {31'b0, gpe_set}, 1);
    check("R7 eject with event", eject_pulse, 32'h0000_0002);
    rd(A_DN, v); check("R3 down with eject", v, 32'h0000_0002);
  endtask

  task automatic t_recapture;
    logic [N-1:0] v;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    rd(A_RM, v); check("R10 recaptured at reset", v, 32'h0000_FFFF);
    rd(A_DN, v); check("R1 down after reset", v, '0);
    step('0, '0, 1, A_EJ, 32'h0001_0000);
    check("R8 new fixed slot blocked", eject_pulse, '0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hot_insert();
    t_cold();
    t_same_cycle();
    t_multi();
    t_eject();
    t_eject_blocked();
    t_regs();
    t_concurrent();
    t_recapture();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule